// File: doc/BRIEF.md
# Dual Channel Self-Trigger Combiner

This block turns a vector of per-channel self-trigger bits into trigger decisions. It holds two identical trigger-logic units, and each has its own configuration. Inside a unit, an enable mask qualifies every channel first. Neighbouring channels (2k, 2k+1) can then be merged with AND or OR. A main stage reduces the whole vector with OR, AND or a majority threshold. The result goes either straight through or through a gate generator of programmable width, which can be set re-triggerable or not. A final polarity bit can invert it.

A second-level selector forms the block's combined trigger from the two unit outputs. It can pick unit A, unit B, their AND or their OR. Each unit output is also available on its own port, for example to feed an acquisition trigger and a trigger output separately. Configuration inputs are expected to stay static while the block is in use. Every change of the self-trigger input reaches the outputs after a fixed latency.

Top module: `stl_dual_trigger`

## Requirements
- R1: While reset is held low, and right after it, each unit output equals that unit's invert bit and the gate is closed.
- R2: A channel whose mask bit is 0 never contributes its own self-trigger bit to any main-stage function.
- R3: Pair mode encoding: 0 passes the masked bits through, 1 drives both bits of pair (2k, 2k+1) with their OR, 2 drives both with their AND, and 3 behaves as 0.
- R4: Under pair mode 1 or 2, a firing pair adds 2 to the majority count.
- R5: Main mode encoding: 0 is the OR of the paired vector, 1 is an AND in which masked-off positions count as true and an all-zero mask gives 0, 2 is majority, and 3 behaves as 0.
- R6: Majority is true in every cycle where the number of set bits in the paired vector is at least the programmed level, so level 0 is always true.
- R7: In linear mode (gate disabled), an input change reaches a unit output on the third rising clock edge after it is applied, and not earlier.
- R8: With the gate enabled, a rising edge of the main result opens the gate for exactly `width` cycles, and width 0 gives no pulse.
- R9: In non-re-triggerable mode, rising edges that arrive while the gate is open are ignored. A rising edge that arrives after the gate closes opens it again.
- R10: In re-triggerable mode, every rising edge reloads the full width.
- R11: An invert bit of 1 inverts the unit output.
- R12: Selector encoding: 0 gives unit A, 1 gives unit B, 2 gives A AND B, and 3 gives A OR B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | NCH | Per-channel self-trigger bits |
| mask_i | input | 2 x NCH | Channel enable mask per unit |
| pair_mode_i | input | 2 x 2 | Pair logic mode per unit |
| main_mode_i | input | 2 x 2 | Main logic mode per unit |
| level_i | input | 2 x clog2(NCH) | Majority level per unit |
| gate_en_i | input | 2 | Gate generator enable per unit |
| retrig_i | input | 2 | Re-triggerable gate per unit |
| width_i | input | 2 x WID_W | Gate width in clock cycles per unit |
| invert_i | input | 2 | Output polarity per unit |
| sel_i | input | 2 | Second-level selector |
| unit_o | output | 2 | Unit outputs (bit 0 = A, bit 1 = B) |
| trig_o | output | 1 | Second-level combined trigger |

## Verification
Two gate functions can act in the same cycle: a new rising edge of the main result, and the countdown of a gate that is already open. The bench provokes this by sending a second one-cycle pulse three cycles after the first one. That pulse reaches the gate while it is still open. The bench then looks at the length of the output pulse: in non-re-triggerable mode the pulse must end exactly `width` cycles after the first edge, and in re-triggerable mode it must end `width` cycles after the second edge. Pairing and majority also meet in one cycle, when a single channel under pair OR is compared against level 2, and this shows whether a pair is counted twice.

// File: rtl/stl_pkg.sv
// Shared encodings for the channel self-trigger combiner.
package stl_pkg;
    typedef enum logic [1:0] {
        PAIR_THRU = 2'd0,
        PAIR_OR   = 2'd1,
        PAIR_AND  = 2'd2,
        PAIR_RSV  = 2'd3
    } pair_mode_e;

    typedef enum logic [1:0] {
        MAIN_OR   = 2'd0,
        MAIN_AND  = 2'd1,
        MAIN_MAJ  = 2'd2,
        MAIN_RSV  = 2'd3
    } main_mode_e;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_AND = 2'd2,
        SEL_OR  = 2'd3
    } sel_mode_e;
endpackage

// File: rtl/stl_unit_core.sv
// Mask, pair logic and main logic of one trigger unit.
// Stage 1 registers the masked and paired vector.
// Stage 2 registers the OR, the masked AND and the population count.
// The main result that leaves the unit is combinational from the stage-2 registers.
// Assumes NCH is even and that the configuration stays static while in use.
module stl_unit_core
    import stl_pkg::*;
#(
    parameter int NCH   = 64,
    localparam int LVL_W = $clog2(NCH),
    localparam int CNT_W = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   trig,
    input  logic [NCH-1:0]   mask,
    input  logic [1:0]       pair_mode,
    input  logic [1:0]       main_mode,
    input  logic [LVL_W-1:0] level,
    output logic             main_o
);
    localparam int NPAIR = NCH / 2;

    pair_mode_e pm;
    main_mode_e mm;
    assign pm = pair_mode_e'(pair_mode);
    assign mm = main_mode_e'(main_mode);

    logic [NCH-1:0] qual;
    logic [NCH-1:0] pv_c;
    assign qual = trig & mask;

    // Pair logic over consecutive channels, one instance per pair.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic lo, hi, both_or, both_and;
        assign lo       = qual[2*k];
        assign hi       = qual[2*k+1];
        assign both_or  = lo | hi;
        assign both_and = lo & hi;
        assign pv_c[2*k]   = (pm == PAIR_OR) ? both_or : (pm == PAIR_AND) ? both_and : lo;
        assign pv_c[2*k+1] = (pm == PAIR_OR) ? both_or : (pm == PAIR_AND) ? both_and : hi;
    end

    logic [NCH-1:0] pv_q, fill_q;
    logic           any_q, paired_q;

    // Stage 1: register the paired vector and the AND fill vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q     <= '0;
            fill_q   <= '0;
            any_q    <= 1'b0;
            paired_q <= 1'b0;
        end else begin
            pv_q     <= pv_c;
            fill_q   <= pv_c | ~mask;
            any_q    <= |mask;
            paired_q <= (pm == PAIR_OR) || (pm == PAIR_AND);
        end
    end

    logic [CNT_W-1:0] cnt_c;

    // Population count of the registered paired vector.
    always_comb begin
        cnt_c = '0;
        for (int i = 0; i < NCH; i++) cnt_c = cnt_c + CNT_W'(pv_q[i]);
    end

    logic             or_q, and_q, paired2_q;
    logic [CNT_W-1:0] cnt_q;

    // Stage 2: register the three reductions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            or_q      <= 1'b0;
            and_q     <= 1'b0;
            cnt_q     <= '0;
            paired2_q <= 1'b0;
        end else begin
            or_q      <= |pv_q;
            and_q     <= any_q & (&fill_q);
            cnt_q     <= cnt_c;
            paired2_q <= paired_q;
        end
    end

    // Main logic: select the reduction, with majority as count >= level.
    always_comb begin
        case (mm)
            MAIN_AND: main_o = and_q;
            MAIN_MAJ: main_o = (cnt_q >= CNT_W'(level));
            default:  main_o = or_q;
        endcase
    end

    // R5
    and_implies_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        and_q |-> or_q);

    // R4
    paired_count_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paired2_q |-> !cnt_q[0]);
endmodule

// File: rtl/stl_gate.sv
// Output shaper of one trigger unit. It either registers the main result as it is
// (linear mode) or runs a gate counter that opens on a rising edge of the main result.
// A polarity bit is applied last. Width is given in clock cycles.
module stl_gate #(
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_i,
    input  logic             gate_en,
    input  logic             retrig,
    input  logic [WID_W-1:0] width,
    input  logic             invert,
    output logic             out_o
);
    logic             prev_q, lin_q;
    logic [WID_W-1:0] cnt_q;
    logic             rise;

    assign rise = main_i & ~prev_q;

    // Linear register, edge detector and gate countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lin_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= main_i;
            lin_q  <= main_i;
            if (!gate_en)
                cnt_q <= '0;
            else if (rise && (retrig || cnt_q == '0))
                cnt_q <= width;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out_o = (gate_en ? (cnt_q != '0) : lin_q) ^ invert;

    // R9
    open_gate_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !retrig && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8
    closed_gate_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && main_i && !prev_q && cnt_q == '0) |=> (cnt_q == $past(width)));

    // R10
    retrig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && retrig && main_i && !prev_q) |=> (cnt_q == $past(width)));
endmodule

// File: rtl/stl_dual_trigger.sv
// Two self-trigger combination units sharing the input vector, plus the
// second-level selector that forms the combined trigger. The latency from
// trig_i to either output is three clock edges.
module stl_dual_trigger
    import stl_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int WID_W = 16,
    localparam int LVL_W = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            trig_i,
    input  logic [1:0][NCH-1:0]       mask_i,
    input  logic [1:0][1:0]           pair_mode_i,
    input  logic [1:0][1:0]           main_mode_i,
    input  logic [1:0][LVL_W-1:0]     level_i,
    input  logic [1:0]                gate_en_i,
    input  logic [1:0]                retrig_i,
    input  logic [1:0][WID_W-1:0]     width_i,
    input  logic [1:0]                invert_i,
    input  logic [1:0]                sel_i,
    output logic [1:0]                unit_o,
    output logic                      trig_o
);
    localparam int NUNIT = 2;

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic main_w;

        stl_unit_core #(.NCH(NCH)) core_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig      (trig_i),
            .mask      (mask_i[u]),
            .pair_mode (pair_mode_i[u]),
            .main_mode (main_mode_i[u]),
            .level     (level_i[u]),
            .main_o    (main_w)
        );

        stl_gate #(.WID_W(WID_W)) gate_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .main_i  (main_w),
            .gate_en (gate_en_i[u]),
            .retrig  (retrig_i[u]),
            .width   (width_i[u]),
            .invert  (invert_i[u]),
            .out_o   (unit_o[u])
        );
    end

    sel_mode_e sel;
    assign sel = sel_mode_e'(sel_i);

    // Second-level selector over the two unit outputs.
    always_comb begin
        case (sel)
            SEL_B:   trig_o = unit_o[1];
            SEL_AND: trig_o = unit_o[0] & unit_o[1];
            SEL_OR:  trig_o = unit_o[0] | unit_o[1];
            default: trig_o = unit_o[0];
        endcase
    end

    // R12
    sel_and_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd2 && trig_o) |-> (unit_o[0] && unit_o[1]));

    // R12
    sel_or_needs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd3 && trig_o) |-> (unit_o[0] || unit_o[1]));
endmodule

// File: tb/stl_dual_trigger_tb.sv
// Self-checking bench: an 8-channel build, a near-exhaustive sweep of unit A,
// then directed gate, polarity, latency and selector cases.
module stl_dual_trigger_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int WW = 16;
    localparam int LW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N-1:0]         trig;
    logic [1:0][N-1:0]    mask;
    logic [1:0][1:0]      pm, mm;
    logic [1:0][LW-1:0]   lvl;
    logic [1:0]           gen, rtg, inv;
    logic [1:0][WW-1:0]   wid;
    logic [1:0]           sel;
    logic [1:0]           uo;
    logic                 to;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stl_dual_trigger #(.NCH(N), .WID_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .mask_i(mask),
        .pair_mode_i(pm), .main_mode_i(mm), .level_i(lvl),
        .gate_en_i(gen), .retrig_i(rtg), .width_i(wid), .invert_i(inv),
        .sel_i(sel), .unit_o(uo), .trig_o(to)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Reference model built from the requirements.
    function automatic logic model(input logic [N-1:0] t, input logic [N-1:0] m,
                                   input logic [1:0] p, input logic [1:0] f, input int l);
        logic [N-1:0] a, v;
        a = t & m;
        for (int k = 0; k < N/2; k++) begin
            case (p)
                2'd1: begin v[2*k] = a[2*k] | a[2*k+1]; v[2*k+1] = a[2*k] | a[2*k+1]; end
                2'd2: begin v[2*k] = a[2*k] & a[2*k+1]; v[2*k+1] = a[2*k] & a[2*k+1]; end
                default: begin v[2*k] = a[2*k]; v[2*k+1] = a[2*k+1]; end
            endcase
        end
        case (f)
            2'd1: return (m != '0) && (&(v | ~m));
            2'd2: return $countones(v) >= l;
            default: return |v;
        endcase
    endfunction

    task automatic cfg_a(input logic [N-1:0] m, input logic [1:0] p, input logic [1:0] f,
                         input int l, input logic ge, input logic rt, input int w, input logic iv);
        mask[0] = m; pm[0] = p; mm[0] = f; lvl[0] = LW'(l);
        gen[0] = ge; rtg[0] = rt; wid[0] = WW'(w); inv[0] = iv;
    endtask

    // Drive a static pattern and check unit A after the pipeline settles.
    task automatic settle_a(input string tag, input logic [N-1:0] t, input logic exp);
        trig = t;
        repeat (3) tick();
        chk(tag, uo[0], exp);
    endtask

    // First pulse at i=0, optional second pulse at i=p2; expected high windows given.
    task automatic gate_case(input string tag, input int w, input logic rt, input int p2,
                             input int e1, input int s2, input int e2);
        cfg_a('1, 2'd0, 2'd0, 0, 1'b0, rt, w, 1'b0);
        trig = '0;
        repeat (6) tick();
        gen[0] = 1'b1;
        repeat (2) tick();
        trig = 8'h01;
        for (int i = 1; i <= 16; i++) begin
            tick();
            chk(tag, uo[0], ((i >= 3 && i <= e1) || (i >= s2 && i <= e2)) && (w > 0));
            trig = (i == p2) ? 8'h01 : 8'h00;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic q0, q1, q2;
        int   age;
        logic [N-1:0] mlist [3];
        int   f, l;
        string tg;

        rst_n = 1'b0; trig = '0; mask = '1; pm = '0; mm = '0; lvl = '0;
        gen = '0; rtg = '0; wid = '0; inv = 2'b10; sel = 2'd0;
        repeat (3) tick();
        // R1: outputs follow the invert bits during reset
        chk("R1", uo[0], 1'b0);
        chk("R1", uo[1], 1'b1);
        chk("R1", to, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1", uo[1], 1'b1);
        inv = 2'b00;

        // Sweep unit A over masks, pair modes, main modes and levels, streaming inputs.
        mlist[0] = 8'hFF; mlist[1] = 8'h5A; mlist[2] = 8'h00;
        for (int mi = 0; mi < 3; mi++) begin
            for (int p = 0; p < 4; p++) begin
                for (int fi = 0; fi < 6; fi++) begin
                    f = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 5) ? 3 : 2;
                    l = (fi == 3) ? 3 : (fi == 4) ? 5 : 0;
                    tg = (f == 2) ? "R6" : (p != 0) ? "R3" : (mi != 0) ? "R2" : "R5";
                    cfg_a(mlist[mi], 2'(p), 2'(f), l, 1'b0, 1'b0, 0, 1'b0);
                    age = 0; q0 = 0; q1 = 0; q2 = 0;
                    for (int t = 0; t < 259; t++) begin
                        logic [N-1:0] v;
                        tick();
                        if (age >= 3) chk(tg, uo[0], q2);
                        q2 = q1; q1 = q0;
                        v = (t < 256) ? N'(t) : 8'hFF;
                        trig = v;
                        q0 = model(v, mlist[mi], 2'(p), 2'(f), l);
                        age++;
                    end
                end
            end
        end

        // R2: a masked-off channel alone does nothing
        cfg_a(8'hFE, 2'd0, 2'd0, 0, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R2", 8'h01, 1'b0);
        settle_a("R2", 8'h03, 1'b1);
        // R4: one channel under pair OR counts twice
        cfg_a(8'hFF, 2'd1, 2'd2, 2, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R4", 8'h01, 1'b1);
        cfg_a(8'hFF, 2'd0, 2'd2, 2, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R4", 8'h01, 1'b0);
        // R5: AND with an all-zero mask stays low
        cfg_a(8'h00, 2'd0, 2'd1, 0, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R5", 8'hFF, 1'b0);
        // R6: level 0 is true with no active channel
        cfg_a(8'hFF, 2'd0, 2'd2, 0, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R6", 8'h00, 1'b1);

        // R7: exact latency of three edges
        cfg_a(8'hFF, 2'd0, 2'd0, 0, 1'b0, 1'b0, 0, 1'b0);
        settle_a("R7", 8'h00, 1'b0);
        trig = 8'h10;
        tick(); chk("R7", uo[0], 1'b0);
        tick(); chk("R7", uo[0], 1'b0);
        tick(); chk("R7", uo[0], 1'b1);

        // Gate generator cases
        gate_case("R8",  5, 1'b0, -1, 7, -1, -1);
        gate_case("R8",  0, 1'b0, -1, 7, -1, -1);
        gate_case("R8",  1, 1'b0, -1, 3, -1, -1);
        gate_case("R9",  5, 1'b0,  3, 7, -1, -1);
        gate_case("R9",  4, 1'b0,  8, 6, 11, 14);
        gate_case("R10", 5, 1'b1,  3, 10, -1, -1);

        // R11: inverted polarity
        cfg_a(8'hFF, 2'd0, 2'd0, 0, 1'b0, 1'b0, 0, 1'b1);
        settle_a("R11", 8'h00, 1'b1);
        settle_a("R11", 8'h04, 1'b0);

        // R12: selector over A (mask 0x0F) and B (mask 0xF0)
        cfg_a(8'h0F, 2'd0, 2'd0, 0, 1'b0, 1'b0, 0, 1'b0);
        mask[1] = 8'hF0; pm[1] = 2'd0; mm[1] = 2'd0; gen[1] = 1'b0; inv[1] = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int pt = 0; pt < 4; pt++) begin
                logic ea, eb, ex;
                ea = pt[0]; eb = pt[1];
                ex = (s == 0) ? ea : (s == 1) ? eb : (s == 2) ? (ea & eb) : (ea | eb);
                sel = 2'(s);
                trig = {3'b000, eb, 3'b000, ea};
                repeat (3) tick();
                chk("R12", to, ex);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule